// File: doc/BRIEF.md
# Row-Bypassing Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (4 by default) into a product of `2*WIDTH` bits. The multiplication is done by an array of full-adder rows. Row 0 is a plain AND of the multiplicand with multiplier bit 0. Each later row j adds the multiplicand, shifted left by j, into the running partial sum, and each row resolves its own carries with a ripple chain. The row that closes the array supplies the upper product bits.

To save switching power, a row whose multiplier bit is zero is put to sleep. The inputs of its adders are gated to constant zero, and a multiplexer at each adder output routes the partial-sum bit from the row above straight through. The carry out of a sleeping row is forced to 0. The product is the same whether or not a row sleeps. Only the adders that do useful work toggle.

The arithmetic core is combinational. A generate option, `OUT_REG`, registers the product and the per-row idle flags, with a synchronous active-low reset. With that option set, the block has one cycle of latency and accepts a new operand pair on every cycle.

Top module: `rbm_mult`

## Requirements
- R1: With `OUT_REG`=1, `prod_o` equals the unsigned product `mcand_i * mplier_i` of the operands sampled at the previous rising clock edge, for every operand pair.
- R2: Product bit 0 equals `mcand_i[0] & mplier_i[0]` of the operands that produced it.
- R3: Bit k of `row_idle_o` (row j = k+1, for j = 1..WIDTH-1) is 1 exactly when multiplier bit j was 0. Bit 0 of the multiplier has no row flag.
- R4: A sleeping row drives zero into its full-adder inputs. Its sum outputs equal the incoming partial-sum bits, and its carry out is 0.
- R5: An active row outputs the sum of the incoming partial-sum window and the multiplicand, with the carry out as the top bit.
- R6: While `rst_n` is 0 at a rising edge, `prod_o` and `row_idle_o` become all zeros on that edge.
- R7: For multiplicand 1111 and multiplier 1001, rows 1 and 2 sleep, row 3 is active (`row_idle_o` = 3'b011), and the product is 135.
- R8: A zero multiplier puts every row to sleep and gives product 0. An all-ones multiplier leaves every row active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| mcand_i | input | WIDTH | Unsigned multiplicand |
| mplier_i | input | WIDTH | Unsigned multiplier; bits 1 and up select rows |
| prod_o | output | 2*WIDTH | Unsigned product |
| row_idle_o | output | WIDTH-1 | Per-row sleep flags, bit k for row k+1 |

## Verification
The bench sweeps the full 256-pair operand space in an order where the multiplier changes slowest. Each row's sleep state is therefore held across 16 multiplicands before it flips, and every mix of sleeping and active rows is crossed with every multiplicand. This separates a wrong sum-pass from a wrong carry-force, because an error in either one shows up only for some mixes of rows. The fixed pair 1111 x 1001 sleeps two adjacent middle rows under a full multiplicand. The all-zero and all-ones multipliers are the two extremes of row activity. A reset checked in the middle of traffic shows that the register clears the product and the flags.

// File: rtl/rbm_pkg.sv
// rbm_pkg: shared helpers for the row-bypassing multiplier.
// Assumes operand widths of at least 2 bits.
package rbm_pkg;

    // Number of bypassable adder rows for a given operand width.
    function automatic int unsigned rbm_rows(input int unsigned w);
        return w - 1;
    endfunction

    // Width of the full product for a given operand width.
    function automatic int unsigned rbm_prod_w(input int unsigned w);
        return 2 * w;
    endfunction

endpackage

// File: rtl/rbm_fa.sv
// rbm_fa: single-bit full adder, the cell every array row is made of.
// Assumes nothing; purely combinational.
module rbm_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    // Sum and majority carry.
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    end

endmodule

// File: rtl/rbm_row.sv
// rbm_row: one adder row of the array. It adds the multiplicand into a
// WIDTH-bit window of the running partial sum, with an internal ripple.
// When en_i is low, the adder inputs are gated to zero, the sum is routed
// around the adders and the carry out is forced to 0.
// Assumes clk/rst_n are used only by the embedded assertions.
module rbm_row #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] win_i,
    input  logic [WIDTH-1:0] mcand_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH-1:0] iso_win;
    logic [WIDTH-1:0] iso_mc;
    logic [WIDTH-1:0] fa_sum;
    logic [WIDTH:0]   fa_carry;

    // Operand isolation: a sleeping row sees constant zero inputs.
    always_comb begin
        iso_win = en_i ? win_i   : '0;
        iso_mc  = en_i ? mcand_i : '0;
    end

    assign fa_carry[0] = 1'b0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            rbm_fa u_fa (
                .x_i (iso_win[i]),
                .y_i (iso_mc[i]),
                .c_i (fa_carry[i]),
                .s_o (fa_sum[i]),
                .c_o (fa_carry[i+1])
            );
        end
    endgenerate

    // Bypass multiplexers: pass-through sum and zero carry when asleep.
    always_comb begin
        sum_o  = en_i ? fa_sum          : win_i;
        cout_o = en_i ? fa_carry[WIDTH] : 1'b0;
    end

    AST_ROW_PASS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> sum_o == win_i);                                   // R4
    AST_ROW_PASS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> cout_o == 1'b0);                                   // R4
    AST_ROW_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> {cout_o, sum_o} == ({1'b0, win_i} + {1'b0, mcand_i})); // R5

endmodule

// File: rtl/rbm_mult.sv
// rbm_mult: unsigned WIDTH x WIDTH array multiplier with row bypassing.
// Row 0 is the AND of the multiplicand with multiplier bit 0. Row j
// (j >= 1) sleeps whenever multiplier bit j is 0. OUT_REG selects a
// registered (1) or purely combinational (0) output.
// Assumes WIDTH >= 2; reset is synchronous and active low.
module rbm_mult
    import rbm_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      mcand_i,
    input  logic [WIDTH-1:0]      mplier_i,
    output logic [2*WIDTH-1:0]    prod_o,
    output logic [WIDTH-2:0]      row_idle_o
);

    localparam int unsigned NROWS = rbm_rows(WIDTH);
    localparam int unsigned PW    = rbm_prod_w(WIDTH);

    // stage[j] is the running partial sum after row j.
    logic [WIDTH-1:0][PW-1:0] stage;
    logic [PW-1:0]            core_prod;
    logic [NROWS-1:0]         core_idle;

    // Row 0: plain partial product, no adder.
    assign stage[0] = PW'(mcand_i & {WIDTH{mplier_i[0]}});

    generate
        for (genvar j = 1; j <= NROWS; j++) begin : g_row
            logic [WIDTH-1:0] r_sum;
            logic             r_cout;
            logic [PW-1:0]    r_next;

            rbm_row #(.WIDTH(WIDTH)) u_row (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (mplier_i[j]),
                .win_i   (stage[j-1][j +: WIDTH]),
                .mcand_i (mcand_i),
                .sum_o   (r_sum),
                .cout_o  (r_cout)
            );

            // Splice the row result into the partial sum at offset j.
            always_comb begin
                r_next               = stage[j-1];
                r_next[j +: WIDTH]   = r_sum;
                r_next[j + WIDTH]    = r_cout;
            end

            assign stage[j]         = r_next;
            assign core_idle[j-1]   = ~mplier_i[j];
        end
    endgenerate

    assign core_prod = stage[NROWS];

    generate
        if (OUT_REG) begin : g_reg
            logic past_ok;

            // Output register with synchronous active-low clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prod_o     <= '0;
                    row_idle_o <= '0;
                end else begin
                    prod_o     <= core_prod;
                    row_idle_o <= core_idle;
                end
            end

            // Tracks that one clean cycle has passed since reset.
            always_ff @(posedge clk) begin
                if (!rst_n) past_ok <= 1'b0;
                else        past_ok <= 1'b1;
            end

            AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok |-> prod_o == $past(PW'(mcand_i) * PW'(mplier_i))); // R1
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> (prod_o == '0 && row_idle_o == '0));            // R6
        end else begin : g_comb
            assign prod_o     = core_prod;
            assign row_idle_o = core_idle;
        end
    endgenerate

    AST_CORE_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        core_prod == PW'(mcand_i) * PW'(mplier_i));                  // R1
    AST_LSB_AND: assert property (@(posedge clk) disable iff (!rst_n)
        core_prod[0] == (mcand_i[0] & mplier_i[0]));                 // R2
    AST_ZERO_MPLIER: assert property (@(posedge clk) disable iff (!rst_n)
        (mplier_i == '0) |-> (core_prod == '0 && &core_idle));       // R8

endmodule

// File: tb/rbm_mult_tb_top.sv
// Bench for rbm_mult (default parameters, registered output).
module rbm_mult_tb_top;

    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic [PW-1:0] prod;
    logic [W-2:0]  idle;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int bypassed_rows = 0;

    always #10 clk = ~clk;   // 50 MHz

    rbm_mult dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mcand_i    (mcand),
        .mplier_i   (mplier),
        .prod_o     (prod),
        .row_idle_o (idle)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int idle_ref(input int b);
        int r = 0;
        for (int j = 1; j < W; j++)
            if (((b >> j) & 1) == 0) r |= (1 << (j - 1));
        return r;
    endfunction

    // Apply one pair at the negedge, check its result one clock later.
    task automatic run_pair(input int a, input int b, input string req);
        int exp_p;
        int exp_i;
        mcand  = W'(a);
        mplier = W'(b);
        exp_p  = a * b;
        exp_i  = idle_ref(b);
        @(posedge clk);
        @(negedge clk);
        check({req, " product"}, int'(prod), exp_p);
        check("R2 lsb", int'(prod[0]), (a & b) & 1);
        check("R3 idle flags", int'(idle), exp_i);
        for (int j = 0; j < W - 1; j++) bypassed_rows += int'(idle[j]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset product", int'(prod), 0);
        check("R6 reset flags", int'(idle), 0);
        rst_n = 1'b1;

        // R7: two middle rows sleep, full multiplicand.
        run_pair(15, 9, "R7");
        check("R7 idle pattern", int'(idle), 3);
        // R8: extremes of row activity.
        run_pair(13, 0, "R8 zero mplier");
        check("R8 all idle", int'(idle), 7);
        run_pair(11, 15, "R8 ones mplier");
        check("R8 none idle", int'(idle), 0);

        // R1, R4, R5: full sweep, multiplier slowest.
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 16; a++)
                run_pair(a, b, "R1 R4 R5 sweep");

        // R6: reset in the middle of traffic.
        mcand  = 4'hF;
        mplier = 4'h5;
        rst_n  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 midrun product", int'(prod), 0);
        check("R6 midrun flags", int'(idle), 0);
        rst_n = 1'b1;
        run_pair(7, 6, "R1 after reset");

        $display("[TB] bypassed row-cycles: %0d", bypassed_rows);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule